// File: doc/BRIEF.md
# Core-Count Turbo Step Governor

This block picks the operating clock frequency of a four-core processor. Software can ask for the top performance state. While it does, the block allows a number of turbo steps above the base frequency, and that number depends on how many cores are currently active. While it does not, the allowed number is zero. The block never jumps straight to the allowed level. On each pacing tick it moves its step counter one step closer to that level, so the frequency climbs and falls in uniform increments.

The block reports three things: the frequency in MHz, the current step index, and a flag that shows it is running above base. A power manager supplies the tick and the request flag. The core-activity mask comes from the cores themselves.

Top module: `turbo_governor`

## Requirements
- R1: When `rst_ni` is asserted low, the step index is 0, the frequency is 2500 MHz and `boost_o` is 0. This holds at once and until the next tick after release.
- R2: `freq_mhz_o` always equals 2500 + 100 × `step_idx_o`.
- R3: When the request is set, the step ceiling depends on the number of set bits in `core_active_i`, whatever their positions. One active core allows 10 steps (3500 MHz), two allow 9 (3400 MHz), three allow 7 (3200 MHz) and four allow 7 (3200 MHz).
- R4: While `perf_req_i` is 0, the ceiling is 0 and the step index falls toward 0.
- R5: With no active cores, the ceiling is 0 even when the request is set.
- R6: When `step_tick_i` is low at a clock edge, the step index does not change.
- R7: A tick changes the step index by exactly one toward the ceiling. If the index already equals the ceiling, the tick leaves it unchanged.
- R8: If more cores become active and the ceiling falls below the current index, the index drops by one per tick until it reaches the new ceiling.
- R9: `boost_o` is 1 exactly when the step index is above 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| core_active_i | input | 4 | One bit per core, 1 = active |
| perf_req_i | input | 1 | Software asks for the highest performance state |
| step_tick_i | input | 1 | Pacing pulse; allows one step per cycle in which it is high |
| freq_mhz_o | output | 13 | Current frequency in MHz |
| step_idx_o | output | 4 | Current turbo step count |
| boost_o | output | 1 | High while running above base frequency |

## Verification
The bench covers four failure modes:
- Ramp speed. A governor that jumped straight to its ceiling, or moved more than one step on a tick, would fail the step-by-step checks on both the rising and the falling ramps.
- Core counting. The mask patterns put the active bits in scattered positions, which catches a design that counts only the low bits or indexes the table in the wrong direction. The step from two to three active cores catches a design that clamps the index at once instead of walking it down.
- Zero-step conditions. The bench removes the request and clears every core bit while the index is above zero. A design that treated either case as "no limit" would keep boosting.
- Hold behaviour. Idle cycles without a tick, and a tick at the ceiling, catch a design that drifts or oscillates around the ceiling.

// File: rtl/turbo_pkg.sv
`timescale 1ns/1ps
package turbo_pkg;
  typedef enum logic [1:0] {
    RAMP_HOLD = 2'd0,
    RAMP_UP   = 2'd1,
    RAMP_DOWN = 2'd2
  } ramp_dir_e;

  localparam int unsigned DEF_NUM_CORES = 4;
  localparam int unsigned DEF_STEP_W    = 4;
  localparam int unsigned DEF_FREQ_W    = 13;
  localparam int unsigned DEF_BASE_MHZ  = 2500;
  localparam int unsigned DEF_STEP_MHZ  = 100;
endpackage

// File: rtl/active_core_count.sv
`timescale 1ns/1ps
module active_core_count #(
  parameter int unsigned NUM_CORES = 4,
  localparam int unsigned CNT_W = $clog2(NUM_CORES + 1)
) (
  input  logic [NUM_CORES-1:0] mask_i,
  output logic [CNT_W-1:0]     count_o
);
  always_comb begin
    count_o = '0;
    for (int i = 0; i < NUM_CORES; i++) begin
      count_o = count_o + CNT_W'(mask_i[i]);
    end
  end
endmodule

// File: rtl/step_ceiling.sv
`timescale 1ns/1ps
module step_ceiling #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned STEP_W    = 4,
  parameter logic [NUM_CORES:0][STEP_W-1:0] STEP_TABLE = '0,
  localparam int unsigned CNT_W = $clog2(NUM_CORES + 1)
) (
  input  logic [CNT_W-1:0]  count_i,
  input  logic              perf_req_i,
  output logic [STEP_W-1:0] ceil_o
);
  logic [NUM_CORES:0][STEP_W-1:0] hit;

  // one masked entry per possible count, OR-reduced below
  for (genvar k = 0; k <= NUM_CORES; k++) begin : g_entry
    if (k == 0) begin : g_idle
      assign hit[k] = '0;
    end else begin : g_live
      assign hit[k] = (count_i == CNT_W'(k)) ? STEP_TABLE[k] : '0;
    end
  end

  always_comb begin
    ceil_o = '0;
    for (int k = 0; k <= NUM_CORES; k++) begin
      ceil_o = ceil_o | hit[k];
    end
    if (!perf_req_i) ceil_o = '0;
  end
endmodule

// File: rtl/step_ramp.sv
`timescale 1ns/1ps
module step_ramp
  import turbo_pkg::*;
#(
  parameter int unsigned STEP_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [STEP_W-1:0] target_i,
  output logic [STEP_W-1:0] step_o
);
  logic [STEP_W-1:0] step_q;
  ramp_dir_e         dir;

  always_comb begin
    if (step_q < target_i)      dir = RAMP_UP;
    else if (step_q > target_i) dir = RAMP_DOWN;
    else                        dir = RAMP_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
    end else if (tick_i) begin
      unique case (dir)
        RAMP_UP:   step_q <= step_q + STEP_W'(1);
        RAMP_DOWN: step_q <= step_q - STEP_W'(1);
        default:   step_q <= step_q;
      endcase
    end
  end

  assign step_o = step_q;
endmodule

// File: rtl/turbo_governor.sv
`timescale 1ns/1ps
module turbo_governor
  import turbo_pkg::*;
#(
  parameter int unsigned NUM_CORES = DEF_NUM_CORES,
  parameter int unsigned STEP_W    = DEF_STEP_W,
  parameter int unsigned FREQ_W    = DEF_FREQ_W,
  parameter int unsigned BASE_MHZ  = DEF_BASE_MHZ,
  parameter int unsigned STEP_MHZ  = DEF_STEP_MHZ,
  // entry k = allowed steps with k active cores
  parameter logic [NUM_CORES:0][STEP_W-1:0] STEP_TABLE =
    {4'd7, 4'd7, 4'd9, 4'd10, 4'd0}
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_CORES-1:0] core_active_i,
  input  logic                 perf_req_i,
  input  logic                 step_tick_i,
  output logic [FREQ_W-1:0]    freq_mhz_o,
  output logic [STEP_W-1:0]    step_idx_o,
  output logic                 boost_o
);
  localparam int unsigned CNT_W = $clog2(NUM_CORES + 1);

  logic [CNT_W-1:0]  active_cnt;
  logic [STEP_W-1:0] ceil_steps;
  logic [STEP_W-1:0] step_cur;

  active_core_count #(.NUM_CORES(NUM_CORES)) u_count (
    .mask_i  (core_active_i),
    .count_o (active_cnt)
  );

  step_ceiling #(
    .NUM_CORES (NUM_CORES),
    .STEP_W    (STEP_W),
    .STEP_TABLE(STEP_TABLE)
  ) u_ceil (
    .count_i    (active_cnt),
    .perf_req_i (perf_req_i),
    .ceil_o     (ceil_steps)
  );

  step_ramp #(.STEP_W(STEP_W)) u_ramp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (step_tick_i),
    .target_i (ceil_steps),
    .step_o   (step_cur)
  );

  assign step_idx_o = step_cur;
  assign freq_mhz_o = FREQ_W'(BASE_MHZ) + FREQ_W'(step_cur) * FREQ_W'(STEP_MHZ);
  assign boost_o    = |step_cur;
endmodule

// File: rtl/turbo_governor_chk.sv
`timescale 1ns/1ps
module turbo_governor_chk #(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned STEP_W    = 4,
  parameter int unsigned FREQ_W    = 13,
  parameter int unsigned BASE_MHZ  = 2500
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_CORES-1:0] core_active_i,
  input logic                 perf_req_i,
  input logic                 step_tick_i,
  input logic [FREQ_W-1:0]    freq_mhz_o,
  input logic [STEP_W-1:0]    step_idx_o,
  input logic                 boost_o
);
  // R6
  no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_tick_i |=> $stable(step_idx_o));

  // R7
  single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (step_idx_o == $past(step_idx_o)) ||
             (step_idx_o == $past(step_idx_o) + STEP_W'(1)) ||
             (step_idx_o == $past(step_idx_o) - STEP_W'(1)));

  // R4
  no_req_falls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_tick_i && !perf_req_i && step_idx_o != '0)
      |=> step_idx_o == $past(step_idx_o) - STEP_W'(1));

  // R5
  no_cores_falls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_tick_i && core_active_i == '0 && step_idx_o != '0)
      |=> step_idx_o == $past(step_idx_o) - STEP_W'(1));

  // R9
  boost_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boost_o == (freq_mhz_o > FREQ_W'(BASE_MHZ)));
endmodule

bind turbo_governor turbo_governor_chk #(
  .NUM_CORES(NUM_CORES), .STEP_W(STEP_W), .FREQ_W(FREQ_W), .BASE_MHZ(BASE_MHZ)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .core_active_i(core_active_i),
  .perf_req_i   (perf_req_i),
  .step_tick_i  (step_tick_i),
  .freq_mhz_o   (freq_mhz_o),
  .step_idx_o   (step_idx_o),
  .boost_o      (boost_o)
);

// File: tb/turbo_governor_test.sv
`timescale 1ns/1ps
module turbo_governor_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  core_active = 4'b0000;
  logic        perf_req = 1'b0;
  logic        step_tick = 1'b0;
  logic [12:0] freq_mhz;
  logic [3:0]  step_idx;
  logic        boost;

  int total = 0;
  int bad = 0;
  int exp_step = 0;

  always #10 clk = ~clk;

  turbo_governor uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .core_active_i(core_active),
    .perf_req_i   (perf_req),
    .step_tick_i  (step_tick),
    .freq_mhz_o   (freq_mhz),
    .step_idx_o   (step_idx),
    .boost_o      (boost)
  );

  function automatic int ceiling(input logic [3:0] m, input logic req);
    int n = $countones(m);
    if (!req) return 0;
    case (n)
      1: return 10;
      2: return 9;
      3: return 7;
      4: return 7;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string tag);
    int ef = 2500 + 100 * exp_step;
    total++;
    if (int'(step_idx) != exp_step) begin
      bad++; $display("FAIL %s step act=%0d exp=%0d", tag, step_idx, exp_step);
    end
    total++;
    if (int'(freq_mhz) != ef) begin
      bad++; $display("FAIL %s/R2 freq act=%0d exp=%0d", tag, freq_mhz, ef);
    end
    total++;
    if (boost != (exp_step > 0)) begin
      bad++; $display("FAIL %s/R9 boost act=%0b exp=%0b", tag, boost, exp_step > 0);
    end
  endtask

  task automatic tick_n(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      int t = ceiling(core_active, perf_req);
      step_tick = 1'b1;
      @(negedge clk);
      step_tick = 1'b0;
      if (exp_step < t) exp_step++;
      else if (exp_step > t) exp_step--;
      check(tag);
    end
  endtask

  task automatic idle_n(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(tag);
    end
  endtask

  task automatic test_reset();
    rst_ni = 1'b0;
    #3;
    exp_step = 0;
    check("R1 async");
    @(negedge clk);
    check("R1 held");
    rst_ni = 1'b1;
    idle_n(2, "R1 after release");
  endtask

  task automatic test_ramp_one_core();
    core_active = 4'b0100;
    perf_req = 1'b1;
    tick_n(12, "R3/R7 one core ramp");
  endtask

  task automatic test_hold();
    idle_n(5, "R6 no tick");
    tick_n(1, "R7 at ceiling");
  endtask

  task automatic test_more_cores();
    core_active = 4'b1001;
    tick_n(2, "R3/R8 two cores");
    core_active = 4'b1011;
    tick_n(4, "R3/R8 three cores");
    core_active = 4'b1111;
    tick_n(2, "R3 four cores");
    core_active = 4'b0110;
    tick_n(3, "R3 two cores up");
  endtask

  task automatic test_no_request();
    perf_req = 1'b0;
    tick_n(10, "R4 request dropped");
    idle_n(2, "R4 stays base");
  endtask

  task automatic test_no_cores();
    perf_req = 1'b1;
    core_active = 4'b0010;
    tick_n(4, "R3 one core short ramp");
    core_active = 4'b0000;
    tick_n(5, "R5 zero cores");
  endtask

  task automatic test_reset_midrun();
    core_active = 4'b1000;
    tick_n(6, "R3 ramp before reset");
    @(negedge clk);
    #5 rst_ni = 1'b0;
    #3;
    exp_step = 0;
    check("R1 mid-run");
    @(negedge clk);
    rst_ni = 1'b1;
    idle_n(1, "R1 mid-run release");
  endtask

  initial begin
    test_reset();
    test_ramp_one_core();
    test_hold();
    test_more_cores();
    test_no_request();
    test_no_cores();
    test_reset_midrun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 20);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule